// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the processor-facing register set of a byte-wide serial port. A 32-bit word-addressed bus reads and writes a small set of registers. Two byte streams connect it to the serial engine: a transmit byte output with a valid/ready handshake, and a receive byte input with a valid/ready handshake. Serialization, baud timing and buffering are handled elsewhere.

Writing the data-out register hands one byte to the transmitter and raises the transmit interrupt source. A received byte lands in a combined status/data word, sets a data-available flag and raises the receive interrupt source. A single level interrupt line is high while any unmasked source is pending. Sources are cleared through an acknowledge register that clears itself. A pending-transmit flag lets the first acknowledge of bit 0 after a transmit re-arm that source instead of clearing it. The status/data word has two read addresses: one is plain, and the other clears data-available when it is read. Receive flow control blocks new bytes while a received byte is still flagged, unless overrun is allowed.

The transmit side is a two-state machine. In `TX_IDLE` no byte is held. A data-out write moves it to `TX_SEND` (transition "load"). In `TX_SEND` the byte is presented with valid high. It returns to `TX_IDLE` when the consumer takes the byte (transition "accept"). It stays in `TX_SEND` with the new byte when another data-out write arrives in that state (transition "reload").

Top module: `sport_regs`

## Requirements
- R1: The register index is `bus_addr >> 2`. Read data appears on `bus_rdata` after the clock edge that samples the read strobe. Indices 8 and above read zero.
- R2: After reset, the status word reads 0x0006_0000 (transmitter-ready bit 17 and transmitter-idle bit 18 set), interrupt status reads 0, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R3: Writing index 0 (data-out) does four things: it stores the word, drives `tx_valid` with the low byte on `tx_data` until `tx_ready` is seen, sets interrupt-status bit 0, and clears status bits 17 and 18 while the byte is held.
- R4: `irq` is high exactly when interrupt status (index 4) ANDed with the mask (index 5) is nonzero. Index 6 reads that AND.
- R5: A write to the acknowledge register (index 7) clears the interrupt-status bits that are set in the written value. Index 7 always reads zero.
- R6: If a transmit is pending, an acknowledge with bit 0 set leaves interrupt-status bit 0 set and clears the pending flag. The next such acknowledge clears bit 0.
- R7: An accepted receive byte (`rx_valid` and `rx_ready`) replaces bits 7:0 of the status word, sets data-available (bit 16) and sets interrupt-status bit 3.
- R8: The status word reads at index 2 with no side effect. Reading it at index 3 returns the same value and then clears bit 16.
- R9: `rx_ready` is high when bit 0 of receive-control (index 1) is set, or when interrupt-status bit 3 is clear. A byte offered while `rx_ready` is low changes nothing.
- R10: A receive event has priority over an acknowledge of bit 3 and over a clearing read in the same cycle.
- R11: Writes to indices 1, 4 and 5 store the word. Writes to indices 2, 3 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit consumer ready |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive flow control |
| rx_data | input | 8 | Receive byte |

## Verification
A wrong transmit state shows in the cycle after the edge: `tx_valid` either drops while the consumer stalls or never rises, and status bits 17/18 disagree with it on the next read. A stale pending flag or acknowledge shows as interrupt-status bit 0 surviving or vanishing one acknowledge too early, which `irq` reflects right after the write edge. A wrong data-available or receive-source state shows in `rx_ready` one cycle after a byte is accepted, and in bit 16 on the read that follows a clearing read.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned IX_DOUT    = 0;
    localparam int unsigned IX_RXCTL   = 1;
    localparam int unsigned IX_STAT    = 2;
    localparam int unsigned IX_STAT_RC = 3;
    localparam int unsigned IX_ISTAT   = 4;
    localparam int unsigned IX_IMASK   = 5;
    localparam int unsigned IX_MSTAT   = 6;
    localparam int unsigned IX_ACK     = 7;
    localparam int unsigned SRC_TX     = 0;
    localparam int unsigned SRC_RX     = 3;
    localparam int unsigned BIT_DAV    = 16;
    localparam int unsigned BIT_TXRDY  = 17;
    localparam int unsigned BIT_TXIDLE = 18;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/sport_tx.sv
module sport_tx
    import sport_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              busy
);
    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) byte_q <= load_byte;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load) state_d = TX_SEND;
            TX_SEND: begin
                if (load)          state_d = TX_SEND;
                else if (tx_ready) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = (state_q == TX_SEND);
        busy     = (state_q == TX_SEND);
        tx_data  = byte_q;
    end
endmodule

// File: rtl/sport_csr.sv
module sport_csr
    import sport_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              tx_busy,
    output logic              rx_ready,
    output logic              tx_load,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);
    logic [WORD_W-1:0] dout_q, rxctl_q, istat_q, imask_q, rdata_q;
    logic [BYTE_W-1:0] rxbyte_q;
    logic              dav_q, pend_q;

    logic [WORD_W-1:0] ack_v, istat_w, istat_d, stat_word, rd_mux;
    logic              wr_ack, rearm, rx_take, rd_clear;

    always_comb begin
        tx_load  = wr && (idx == IDX_W'(IX_DOUT));
        wr_ack   = wr && (idx == IDX_W'(IX_ACK));
        rd_clear = rd && (idx == IDX_W'(IX_STAT_RC));
        rearm    = wr_ack && pend_q && wdata[SRC_TX];
        rx_ready = rxctl_q[0] || !istat_q[SRC_RX];
        rx_take  = rx_valid && rx_ready;

        ack_v = wr_ack ? wdata : '0;
        if (rearm) ack_v[SRC_TX] = 1'b0;

        istat_w = (wr && idx == IDX_W'(IX_ISTAT)) ? wdata : istat_q;
        if (tx_load || rearm) istat_w[SRC_TX] = 1'b1;
        istat_d = istat_w & ~ack_v;
        if (rx_take) istat_d[SRC_RX] = 1'b1;

        stat_word = '0;
        stat_word[BYTE_W-1:0] = rxbyte_q;
        stat_word[BIT_DAV]    = dav_q;
        stat_word[BIT_TXRDY]  = !tx_busy;
        stat_word[BIT_TXIDLE] = !tx_busy;

        unique case (idx)
            IDX_W'(IX_DOUT):    rd_mux = dout_q;
            IDX_W'(IX_RXCTL):   rd_mux = rxctl_q;
            IDX_W'(IX_STAT):    rd_mux = stat_word;
            IDX_W'(IX_STAT_RC): rd_mux = stat_word;
            IDX_W'(IX_ISTAT):   rd_mux = istat_q;
            IDX_W'(IX_IMASK):   rd_mux = imask_q;
            IDX_W'(IX_MSTAT):   rd_mux = istat_q & imask_q;
            default:            rd_mux = '0;
        endcase

        irq   = |(istat_q & imask_q);
        rdata = rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q   <= '0;
            rxctl_q  <= '0;
            istat_q  <= '0;
            imask_q  <= '0;
            rdata_q  <= '0;
            rxbyte_q <= '0;
            dav_q    <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            istat_q <= istat_d;
            if (tx_load) dout_q <= wdata;
            if (wr && idx == IDX_W'(IX_RXCTL)) rxctl_q <= wdata;
            if (wr && idx == IDX_W'(IX_IMASK)) imask_q <= wdata;
            if (rd) rdata_q <= rd_mux;
            if (tx_load)    pend_q <= 1'b1;
            else if (rearm) pend_q <= 1'b0;
            if (rx_take) begin
                rxbyte_q <= rx_data;
                dav_q    <= 1'b1;
            end else if (rd_clear) begin
                dav_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sport_regs.sv
module sport_regs
    import sport_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr, rd, tx_load, tx_busy;

    assign idx = bus_addr[ADDR_W-1:2];
    assign wr  = bus_sel && bus_we;
    assign rd  = bus_sel && !bus_we;

    sport_csr #(.IDX_W(IDX_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .idx(idx),
        .wdata(bus_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_busy(tx_busy), .rx_ready(rx_ready), .tx_load(tx_load),
        .rdata(bus_rdata), .irq(irq)
    );

    sport_tx #(.DATA_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load),
        .load_byte(bus_wdata[BYTE_W-1:0]), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .busy(tx_busy)
    );
endmodule

// File: rtl/sport_regs_chk.sv
module sport_regs_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [7:0]        rx_data,
    input logic              rxctl0,
    input logic              dav,
    input logic [7:0]        stat_lo
);
    logic [ADDR_W-3:0] ix;
    assign ix = bus_addr[ADDR_W-1:2];

    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);

    p_tx_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && ix == 0) |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

    p_rx_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (dav && stat_lo == $past(rx_data)));

    p_dav_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && ix == 3 && !(rx_valid && rx_ready)) |=> !dav);

    p_flow_after_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (rx_ready == rxctl0));
endmodule

bind sport_regs sport_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rxctl0(u_csr.rxctl_q[0]),
    .dav(u_csr.dav_q), .stat_lo(u_csr.rxbyte_q)
);

// File: tb/sport_regs_test.sv
`timescale 1ns/1ps
module sport_regs_test;
    localparam int AW = 6;
    logic          clk = 0, rst_n = 0;
    logic          bus_sel = 0, bus_we = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic          irq, tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
    logic [7:0]    tx_data, rx_data = '0;
    int            n_chk = 0, n_err = 0;
    logic [31:0]   rv;

    always #5 clk = ~clk;

    sport_regs #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int ix, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = AW'(ix * 4); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input int ix, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = AW'(ix * 4);
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_data = b;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic t_reset;
        rd(2, rv); check("R2 status", rv, 32'h0006_0000);
        rd(4, rv); check("R2 istat", rv, 0);
        check("R2 irq/txv/rxr", {irq, tx_valid, rx_ready}, 3'b001);
    endtask

    task automatic t_tx;
        wr(5, 32'h9);
        wr(0, 32'h0000_01A5);
        check("R3 tx byte", {tx_valid, tx_data}, {1'b1, 8'hA5});
        check("R4 irq tx", irq, 1);
        repeat (2) @(negedge clk);
        check("R3 hold", tx_valid, 1);
        rd(2, rv); check("R3 busy bits", rv[18:16], 3'b000);
        @(negedge clk); tx_ready = 1;
        @(negedge clk); tx_ready = 0;
        check("R3 released", tx_valid, 0);
        rd(0, rv); check("R3 stored", rv, 32'h0000_01A5);
        rd(4, rv); check("R3 istat0", rv, 32'h1);
    endtask

    task automatic t_rearm;
        wr(7, 32'h1);
        rd(4, rv); check("R6 rearm", rv, 32'h1);
        check("R6 irq kept", irq, 1);
        wr(7, 32'h1);
        rd(4, rv); check("R5 cleared", rv, 0);
        check("R5 irq low", irq, 0);
        rd(7, rv); check("R5 ack reads 0", rv, 0);
    endtask

    task automatic t_rx;
        rx_send(8'h3C);
        check("R7 irq", irq, 1);
        rd(2, rv); check("R7 capture", rv, 32'h0007_003C);
        rd(2, rv); check("R8 plain no clear", rv, 32'h0007_003C);
        rd(3, rv); check("R8 clear alias value", rv, 32'h0007_003C);
        rd(2, rv); check("R8 dav cleared", rv, 32'h0006_003C);
    endtask

    task automatic t_flow;
        check("R9 blocked", rx_ready, 0);
        rx_send(8'h55);
        rd(2, rv); check("R9 ignored", rv, 32'h0006_003C);
        wr(1, 32'h1);
        check("R9 overrun allowed", rx_ready, 1);
        rx_send(8'h55);
        rd(2, rv); check("R9 accepted", rv, 32'h0007_0055);
        wr(1, 32'h0);
        check("R9 blocked again", rx_ready, 0);
        wr(7, 32'h8);
        check("R9 ack frees", rx_ready, 1);
    endtask

    task automatic t_mask;
        wr(4, 32'h9);
        rd(4, rv); check("R11 istat store", rv, 32'h9);
        wr(5, 32'h0);
        check("R4 masked irq", irq, 0);
        rd(6, rv); check("R4 mstat zero", rv, 0);
        wr(5, 32'h8);
        check("R4 irq rx", irq, 1);
        rd(6, rv); check("R4 mstat", rv, 32'h8);
        wr(2, 32'hFFFF_FFFF); wr(3, 32'h0); wr(6, 32'h0);
        rd(2, rv); check("R11 status ro", rv, 32'h0007_0055);
        rd(6, rv); check("R11 mstat ro", rv, 32'h8);
        rd(1, rv); check("R11 rxctl store", rv, 0);
        rd(9, rv); check("R1 unmapped", rv, 0);
    endtask

    task automatic t_race;
        wr(4, 32'h0);
        rd(3, rv);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = AW'(7 * 4); bus_wdata = 32'h8;
        rx_valid = 1; rx_data = 8'h77;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; rx_valid = 0;
        rd(4, rv); check("R10 rx beats ack", rv, 32'h8);
        wr(1, 32'h1);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = AW'(3 * 4);
        rx_valid = 1; rx_data = 8'h12;
        @(negedge clk);
        bus_sel = 0; rx_valid = 0;
        rd(2, rv); check("R10 rx beats clear", rv, 32'h0007_0012);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_tx;
        t_rearm;
        t_rx;
        t_flow;
        t_mask;
        t_race;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule